// File: doc/BRIEF.md
# Narrow-Access Register Write Coalescing Bridge

This bridge connects a host bus that issues byte, halfword and word register accesses to a register file that only understands whole 32-bit words. A narrow write becomes a word read, a lane merge and a word write. A narrow read becomes a word read followed by lane extraction. A word access passes through unchanged.

Writes to the two transfer-setup halfwords (block size at 0x04, block count at 0x06) and the transfer-mode halfword (0x0C) are held in two shadow words and do not go downstream at that point. A halfword write to the command register (0x0E) flushes the block shadow, if one is held, as one word write. The command halfword is then merged into the transfer-mode shadow and written as a second word write. Because of this, two writes landing in the same downstream word never follow each other closely enough to be lost across the card-clock domain crossing.

When the card clock is slow, every downstream write is followed by a guard wait, counted in bridge cycles. While the bridge is busy it holds off the host with `up_ready` low.

Top module: `sdreg_coalesce_bridge`

## Requirements
- R1: A narrow access uses lane shift `addr[1:0]*8`. Its downstream word address is the access address with bits [1:0] cleared. Size codes: 0 = byte, 1 = halfword, 2 or 3 = word.
- R2: A halfword write to 0x04 or 0x06 issues no downstream write. It merges into the block shadow, starting from the shadow if the shadow is valid and otherwise from a downstream read of word 0x04, and then marks the shadow valid.
- R3: A halfword write to 0x0C issues no downstream write. It merges into the transfer-mode shadow, starting from a downstream read of word 0x0C, and marks that shadow valid.
- R4: A halfword write to 0x0E does the following, in order. If the block shadow is valid, it writes that shadow to word 0x04 and clears its valid flag. It then merges the halfword into the transfer-mode shadow (whatever its flag), clears that flag, and writes the merged value to word 0x0C.
- R5: A halfword read of 0x0C returns the transfer-mode shadow while that shadow is valid. A halfword read of 0x04 or 0x06 returns the block shadow while that shadow is valid. In both cases the result is shifted by the lane and masked to 16 bits.
- R6: Every byte write, and every halfword write to any other address, is a read-modify-write of only the addressed lane. Byte reads, and halfword reads not covered by R5, return the lane taken from a downstream word read.
- R7: With `card_hz` at or below 400000, each downstream write is followed by a wait of N×C bridge cycles before the next downstream write. N = ceil(4000000/`card_hz`), or N = 10 when `card_hz` is 0. C = `cyc_per_us`, with 0 treated as 1. Above 400000 Hz there is no wait, so the two writes of a flush land on consecutive cycles.
- R8: A word read returns the downstream word even while a shadow covers it. Neither word reads nor word writes change the shadow state.
- R9: Reset clears both shadow flags and both shadow words. After reset, `up_ready` is 1 and `dn_req` and `up_rvalid` are 0.
- R10: `up_ready` is low while an access is in progress. Read data is given by a one-cycle `up_rvalid` pulse, after which the bridge is ready again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Host access request |
| up_ready | output | 1 | Bridge can accept an access |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| up_addr | input | AW | Byte address |
| up_wdata | input | 32 | Write data, right-aligned |
| up_rvalid | output | 1 | Read data valid pulse |
| up_rdata | output | 32 | Read data, right-aligned |
| dn_req | output | 1 | Downstream word access |
| dn_write | output | 1 | Downstream access is a write |
| dn_addr | output | AW | Downstream word address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, one cycle after a read request |
| card_hz | input | HZ_W | Card clock frequency in Hz |
| cyc_per_us | input | CPU_W | Bridge cycles per microsecond |

## Verification
The hardest state to reach from the ports is a command write that arrives while both shadows hold merged data built from several partial writes. That is the only case that produces the back-to-back flush pair whose order and spacing matter. Directed sequences build the shadows piece by piece and issue the command under several card-clock settings, including zero, the exact threshold and one hertz above it, measuring the cycle gap between the two downstream writes. A seeded random phase aims most accesses at the four shadowed halfwords so that flushes occur with many different shadow contents. A bench model predicts every read.

// File: rtl/sdreg_coalesce_bridge.sv
module sdreg_coalesce_bridge #(
  parameter int AW = 8,
  parameter int HZ_W = 32,
  parameter int CPU_W = 8,
  parameter logic [AW-1:0] BLKSZ_OFS = 'h04,
  parameter logic [AW-1:0] BLKCNT_OFS = 'h06,
  parameter logic [AW-1:0] XFER_OFS = 'h0C,
  parameter logic [AW-1:0] CMD_OFS = 'h0E,
  parameter int SLOW_HZ = 400000,
  parameter int GUARD_CLKS = 4,
  parameter int ZERO_US = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             up_valid,
  output logic             up_ready,
  input  logic             up_write,
  input  logic [1:0]       up_size,
  input  logic [AW-1:0]    up_addr,
  input  logic [31:0]      up_wdata,
  output logic             up_rvalid,
  output logic [31:0]      up_rdata,
  output logic             dn_req,
  output logic             dn_write,
  output logic [AW-1:0]    dn_addr,
  output logic [31:0]      dn_wdata,
  input  logic [31:0]      dn_rdata,
  input  logic [HZ_W-1:0]  card_hz,
  input  logic [CPU_W-1:0] cyc_per_us
);

  localparam logic [AW-1:0] BLK_WORD = {BLKSZ_OFS[AW-1:2], 2'b00};
  localparam int US_W = $clog2(ZERO_US + 1);
  localparam logic [HZ_W+1:0] LIMIT = (HZ_W+2)'(GUARD_CLKS * 1000000);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_MERGE, S_WR_BLK, S_WR_MAIN, S_WAIT, S_RESP} st_t;

  st_t st;
  logic             op_w;
  logic [1:0]       op_sz;
  logic [AW-1:0]    op_a;
  logic [31:0]      op_d;
  logic [31:0]      sh_blk, sh_cmd, wbuf, rd_q;
  logic             blk_v, cmd_v, pend;
  logic [CPU_W-1:0] sub;
  logic [US_W-1:0]  us;
  logic [HZ_W+1:0]  acc;

  function automatic logic [4:0] lane(input logic [AW-1:0] a);
    return {a[1:0], 3'b000};
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [1:0] sz,
                                        input logic [AW-1:0] a, input logic [31:0] d);
    logic [31:0] m, v;
    m = (sz == 2'd0 ? 32'h0000_00FF : 32'h0000_FFFF) << lane(a);
    v = {16'h0, d[15:0]} << lane(a);
    return (old & ~m) | (v & m);
  endfunction

  function automatic logic [31:0] extract(input logic [31:0] w, input logic [1:0] sz,
                                          input logic [AW-1:0] a);
    return (w >> lane(a)) & (sz == 2'd0 ? 32'h0000_00FF : 32'h0000_FFFF);
  endfunction

  wire in_half = (up_size == 2'd1);
  wire in_blk  = in_half && (up_addr == BLKSZ_OFS || up_addr == BLKCNT_OFS);
  wire in_xfer = in_half && (up_addr == XFER_OFS);
  wire in_cmd  = in_half && (up_addr == CMD_OFS);
  wire op_half = (op_sz == 2'd1);
  wire op_blk  = op_half && (op_a == BLKSZ_OFS || op_a == BLKCNT_OFS);
  wire op_xfer = op_half && (op_a == XFER_OFS);

  wire slow = card_hz <= HZ_W'(SLOW_HZ);
  wire [CPU_W-1:0] cpu_last = (cyc_per_us == '0) ? '0 : cyc_per_us - 1'b1;
  wire [HZ_W+1:0] acc_nx = acc + {2'b00, card_hz};
  wire wait_done = (card_hz == '0) ? (us == US_W'(ZERO_US - 1)) : (acc_nx >= LIMIT);

  assign up_ready  = (st == S_IDLE);
  assign up_rvalid = (st == S_RESP);
  assign up_rdata  = rd_q;
  assign dn_req    = (st == S_FETCH) || (st == S_WR_BLK) || (st == S_WR_MAIN);
  assign dn_write  = (st == S_WR_BLK) || (st == S_WR_MAIN);
  assign dn_addr   = (st == S_WR_BLK) ? BLK_WORD : {op_a[AW-1:2], 2'b00};
  assign dn_wdata  = (st == S_WR_BLK) ? sh_blk : wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_w <= 1'b0; op_sz <= '0; op_a <= '0; op_d <= '0;
      sh_blk <= '0; sh_cmd <= '0; wbuf <= '0; rd_q <= '0;
      blk_v <= 1'b0; cmd_v <= 1'b0; pend <= 1'b0;
      sub <= '0; us <= '0; acc <= '0;
    end else begin
      case (st)
        S_IDLE: if (up_valid) begin
          op_w <= up_write; op_sz <= up_size; op_a <= up_addr; op_d <= up_wdata;
          if (!up_write) begin
            if (in_xfer && cmd_v) begin
              rd_q <= extract(sh_cmd, up_size, up_addr);
              st <= S_RESP;
            end else if (in_blk && blk_v) begin
              rd_q <= extract(sh_blk, up_size, up_addr);
              st <= S_RESP;
            end else st <= S_FETCH;
          end else if (up_size[1]) begin
            wbuf <= up_wdata;
            st <= S_WR_MAIN;
          end else if (in_cmd) begin
            wbuf <= merge(sh_cmd, up_size, up_addr, up_wdata);
            cmd_v <= 1'b0;
            st <= blk_v ? S_WR_BLK : S_WR_MAIN;
          end else if (in_blk && blk_v) begin
            sh_blk <= merge(sh_blk, up_size, up_addr, up_wdata);
          end else st <= S_FETCH;
        end
        S_FETCH: st <= S_MERGE;
        S_MERGE: begin
          if (!op_w) begin
            rd_q <= op_sz[1] ? dn_rdata : extract(dn_rdata, op_sz, op_a);
            st <= S_RESP;
          end else if (op_xfer) begin
            sh_cmd <= merge(dn_rdata, op_sz, op_a, op_d);
            cmd_v <= 1'b1;
            st <= S_IDLE;
          end else if (op_blk) begin
            sh_blk <= merge(dn_rdata, op_sz, op_a, op_d);
            blk_v <= 1'b1;
            st <= S_IDLE;
          end else begin
            wbuf <= merge(dn_rdata, op_sz, op_a, op_d);
            st <= S_WR_MAIN;
          end
        end
        S_WR_BLK: begin
          blk_v <= 1'b0;
          pend <= 1'b1;
          sub <= '0; us <= '0; acc <= '0;
          st <= slow ? S_WAIT : S_WR_MAIN;
        end
        S_WR_MAIN: begin
          pend <= 1'b0;
          sub <= '0; us <= '0; acc <= '0;
          st <= slow ? S_WAIT : S_IDLE;
        end
        S_WAIT: begin
          if (sub >= cpu_last) begin
            sub <= '0;
            us <= us + 1'b1;
            acc <= acc_nx;
            if (wait_done) st <= pend ? S_WR_MAIN : S_IDLE;
          end else sub <= sub + 1'b1;
        end
        S_RESP: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  p_flush_hits_blk_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_v) |-> $past(dn_req && dn_write && dn_addr == BLK_WORD));

  p_flush_then_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WR_BLK) |=> (st == S_WAIT || st == S_WR_MAIN));

  p_slow_spacing_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_req && dn_write && slow) |=> !dn_req);

  p_rvalid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    up_rvalid |=> (!up_rvalid && up_ready));

  p_shadow_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && up_write && in_blk && blk_v) |=> (!dn_req && up_ready));

  p_word_keeps_shadow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && up_ready && up_size[1]) |=> ($stable(blk_v) && $stable(cmd_v)));

endmodule

// File: tb/sdreg_coalesce_bridge_tb.sv
module sdreg_coalesce_bridge_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0, up_write = 1'b0;
  logic [1:0] up_size = '0;
  logic [7:0] up_addr = '0;
  logic [31:0] up_wdata = '0;
  logic up_ready, up_rvalid;
  logic [31:0] up_rdata;
  logic dn_req, dn_write;
  logic [7:0] dn_addr;
  logic [31:0] dn_wdata;
  logic [31:0] dn_rdata;
  logic [31:0] card_hz = 32'd50_000_000;
  logic [7:0] cyc_per_us = 8'd4;

  always #5 clk = ~clk;

  sdreg_coalesce_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_write(up_write), .up_size(up_size), .up_addr(up_addr), .up_wdata(up_wdata),
    .up_rvalid(up_rvalid), .up_rdata(up_rdata), .dn_req(dn_req), .dn_write(dn_write),
    .dn_addr(dn_addr), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
    .card_hz(card_hz), .cyc_per_us(cyc_per_us));

  int checks = 0, errors = 0;
  longint cyc = 0, last_wr = 0, prev_wr = 0;
  int wr_cnt = 0;
  logic [7:0] last_wa = '0, prev_wa = '0;
  logic [31:0] mem [0:63];
  logic [31:0] exp_mem [0:63];
  logic [31:0] m_blk, m_cmd;
  bit m_blkv, m_cmdv;

  function automatic logic [31:0] init_word(input int i);
    return 32'h5A3C_9600 ^ (i * 32'h0103_0507);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= init_word(i);
      dn_rdata <= '0;
    end else if (dn_req) begin
      if (dn_write) begin
        mem[dn_addr[7:2]] <= dn_wdata;
        prev_wr <= last_wr; last_wr <= cyc;
        prev_wa <= last_wa; last_wa <= dn_addr;
        wr_cnt <= wr_cnt + 1;
      end else dn_rdata <= mem[dn_addr[7:2]];
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge_m(input logic [31:0] old, input logic [1:0] sz,
                                          input logic [7:0] a, input logic [31:0] d);
    int sh = a[1:0] * 8;
    logic [31:0] m = (sz == 0 ? 32'hFF : 32'hFFFF) << sh;
    return (old & ~m) | (({16'h0, d[15:0]} << sh) & m);
  endfunction

  function automatic logic [31:0] lane_m(input logic [31:0] w, input logic [1:0] sz, input logic [7:0] a);
    return (w >> (a[1:0] * 8)) & (sz == 0 ? 32'hFF : 32'hFFFF);
  endfunction

  function automatic bit is_blk(input logic [1:0] sz, input logic [7:0] a);
    return sz == 1 && (a == 8'h04 || a == 8'h06);
  endfunction

  task automatic model_write(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    int wi = a[7:2];
    if (sz[1]) exp_mem[wi] = d;
    else if (sz == 1 && a == 8'h0E) begin
      if (m_blkv) begin exp_mem[1] = m_blk; m_blkv = 0; end
      exp_mem[3] = merge_m(m_cmd, sz, a, d);
      m_cmdv = 0;
    end else if (is_blk(sz, a)) begin
      m_blk = merge_m(m_blkv ? m_blk : exp_mem[1], sz, a, d);
      m_blkv = 1;
    end else if (sz == 1 && a == 8'h0C) begin
      m_cmd = merge_m(exp_mem[3], sz, a, d);
      m_cmdv = 1;
    end else exp_mem[wi] = merge_m(exp_mem[wi], sz, a, d);
  endtask

  function automatic logic [31:0] model_read(input logic [1:0] sz, input logic [7:0] a);
    if (sz[1]) return exp_mem[a[7:2]];
    if (sz == 1 && a == 8'h0C && m_cmdv) return lane_m(m_cmd, sz, a);
    if (is_blk(sz, a) && m_blkv) return lane_m(m_blk, sz, a);
    return lane_m(exp_mem[a[7:2]], sz, a);
  endfunction

  task automatic access(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    up_valid = 1; up_write = w; up_size = sz; up_addr = a; up_wdata = d;
    @(negedge clk);
    up_valid = 0;
    r = '0;
    if (!w) begin
      while (!up_rvalid) @(negedge clk);
      r = up_rdata;
    end
  endtask

  task automatic wr(input logic [1:0] sz, input logic [7:0] a, input logic [31:0] d);
    logic [31:0] r;
    access(1, sz, a, d, r);
    model_write(sz, a, d);
  endtask

  task automatic rd_check(input logic [1:0] sz, input logic [7:0] a, input string req);
    logic [31:0] r, e;
    e = model_read(sz, a);
    access(0, sz, a, 0, r);
    chk(r === e, req, r, e);
  endtask

  task automatic settle();
    @(negedge clk);
    while (!up_ready) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic longint exp_gap(input logic [31:0] hz, input logic [7:0] c);
    longint n, cc;
    if (hz > 400000) return 1;
    n = (hz == 0) ? 10 : (4000000 + hz - 1) / hz;
    cc = (c == 0) ? 1 : c;
    return 1 + n * cc;
  endfunction

  task automatic flush_gap(input logic [31:0] hz, input logic [7:0] c);
    longint g;
    card_hz = hz; cyc_per_us = c;
    wr(1, 8'h04, 32'h0200 + hz[15:0]);
    wr(1, 8'h0C, 32'h0011);
    wr(1, 8'h0E, 32'h0007);
    settle();
    g = last_wr - prev_wr;
    chk(g == exp_gap(hz, c), "R7 flush gap", 32'(g), 32'(exp_gap(hz, c)));
    chk(prev_wa == 8'h04 && last_wa == 8'h0C, "R4 flush order", {prev_wa, last_wa}, 32'h040C);
  endtask

  bit done = 0;
  initial begin
    for (int k = 0; k < 150000 && !done; k++) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n0;
    longint g;
    void'($urandom(32'h0C0A_1E5C));
    for (int i = 0; i < 64; i++) exp_mem[i] = init_word(i);
    m_blk = 0; m_cmd = 0; m_blkv = 0; m_cmdv = 0;
    repeat (4) @(negedge clk);
    chk(up_ready === 1'b1 && dn_req === 1'b0 && up_rvalid === 1'b0, "R9 reset outputs",
        {29'b0, up_ready, dn_req, up_rvalid}, 32'h4);
    rst_n = 1;
    @(negedge clk);
    rd_check(1, 8'h0C, "R9 no shadow after reset");
    rd_check(1, 8'h06, "R9 no block shadow after reset");

    n0 = wr_cnt;
    wr(1, 8'h04, 32'h1234);
    settle();
    chk(wr_cnt == n0, "R2 no downstream write", wr_cnt, n0);
    rd_check(1, 8'h04, "R5 block size shadow");
    rd_check(1, 8'h06, "R2 count half from downstream base");
    wr(1, 8'h06, 32'hBEEF);
    settle();
    chk(wr_cnt == n0 && mem[1] == init_word(1), "R2 shadow merge kept off bus", mem[1], init_word(1));
    rd_check(1, 8'h06, "R5 block count shadow");

    wr(1, 8'h0C, 32'h0033);
    settle();
    chk(wr_cnt == n0, "R3 no downstream write", wr_cnt, n0);
    rd_check(1, 8'h0C, "R5 transfer mode shadow");
    rd_check(2, 8'h04, "R8 word read bypasses shadow");
    rd_check(1, 8'h04, "R8 shadow intact after word read");
    wr(2, 8'h08, 32'hCAFE_F00D);
    rd_check(1, 8'h06, "R8 shadow intact after word write");

    wr(1, 8'h0E, 32'h001A);
    settle();
    chk(wr_cnt == n0 + 3, "R4 two flush writes", wr_cnt, n0 + 3);
    chk(mem[1] == 32'hBEEF_1234, "R4 block word flushed", mem[1], 32'hBEEF_1234);
    chk(mem[3] == 32'h001A_0033, "R4 command word merged", mem[3], 32'h001A_0033);
    chk(prev_wa == 8'h04 && last_wa == 8'h0C && last_wr - prev_wr == 1, "R4 order and fast gap",
        {prev_wa, last_wa, 16'(last_wr - prev_wr)}, 32'h040C_0001);
    rd_check(1, 8'h0C, "R4 transfer shadow cleared");

    n0 = wr_cnt;
    wr(1, 8'h0E, 32'h0055);
    settle();
    chk(wr_cnt == n0 + 1 && last_wa == 8'h0C, "R4 command alone one write", wr_cnt, n0 + 1);

    for (int l = 0; l < 4; l++) begin
      wr(0, 8'h10 + 8'(l), 32'h00A0 + l);
      rd_check(0, 8'h10 + 8'(l), "R6 byte lane");
    end
    rd_check(2, 8'h10, "R1 byte lanes assembled");
    wr(1, 8'h16, 32'h7E7E);
    rd_check(2, 8'h14, "R1 upper half lane");
    wr(1, 8'h1B, 32'h9911);
    rd_check(2, 8'h18, "R6 half at lane 3 truncated");
    rd_check(1, 8'h1B, "R6 half read at lane 3");

    flush_gap(32'd100000, 8'd3);
    flush_gap(32'd0, 8'd3);
    flush_gap(32'd300000, 8'd2);
    flush_gap(32'd400000, 8'd1);
    flush_gap(32'd400001, 8'd5);
    flush_gap(32'd0, 8'd0);

    card_hz = 32'd200000; cyc_per_us = 8'd2;
    wr(0, 8'h20, 32'h11);
    wr(0, 8'h21, 32'h22);
    settle();
    g = last_wr - prev_wr;
    chk(g >= exp_gap(card_hz, cyc_per_us), "R7 plain write spacing", 32'(g), 32'(exp_gap(card_hz, cyc_per_us)));
    chk(up_ready === 1'b1, "R10 ready after wait", {31'b0, up_ready}, 1);

    card_hz = 32'd50_000_000; cyc_per_us = 8'd4;
    for (int t = 0; t < 500; t++) begin
      logic [7:0] a;
      logic [1:0] sz;
      logic [31:0] d;
      int p = $urandom_range(0, 7);
      case (p)
        0: a = 8'h04; 1: a = 8'h06; 2: a = 8'h0C; 3: a = 8'h0E;
        default: a = 8'($urandom_range(0, 31));
      endcase
      sz = 2'($urandom_range(0, 2));
      if (sz[1]) a = {a[7:2], 2'b00};
      d = $urandom;
      if (t % 97 == 50) card_hz = 32'd250000;
      if (t % 97 == 60) card_hz = 32'd50_000_000;
      if ($urandom_range(0, 1) == 1) wr(sz, a, d);
      else rd_check(sz, a, "R6 random read");
    end
    settle();
    for (int i = 0; i < 8; i++)
      chk(mem[i] == exp_mem[i], "R6 final downstream contents", mem[i], exp_mem[i]);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule